// File: doc/BRIEF.md
# Fault-Hardened Signature Verdict Comparator

This block makes the last decision of a signature check. It receives two 256-bit compressed point encodings: the one carried in the signature and the one recomputed from the message and public key. It then produces a 64-bit verdict word. Equality is judged by XOR-ing the two encodings and testing the whole difference for zero.

The judgement is made twice. Before each pass the equality flag is forced to "not equal". The verdict register is set to the rejection code (1) as soon as a request is accepted. It is overwritten with the acceptance constant 0xBA11FADE0B5E55ED only after both passes agree on a match. That constant is not stored anywhere as a single word: an accumulator is seeded with its top byte and then rotated left by one byte and OR-ed with the next byte, once per cycle. A single upset in the decision path therefore has to do more than flip one bit to forge acceptance.

If the two passes disagree, the block rejects and raises a sticky alarm. Only reset clears the alarm. The operands are not captured. The caller holds them steady from start until done, so any change between the passes shows up as a disagreement.

Top module: `verdict_top`

## Requirements
- R1: After reset, result reads 1 (the rejection code), done is 0 and alarm is 0.
- R2: In the cycle after start is accepted in the idle state, result reads 1 whatever the previous verdict was.
- R3: Two encodings that differ in any single bit of the 256 lead to a verdict of exactly 1.
- R4: Two identical encodings, held through both passes, lead to a verdict of 0xBA11FADE0B5E55ED.
- R5: Counting the rising edge that accepts start as edge 1, done is first seen high after edge 6 on a rejection and after edge 14 on an acceptance.
- R6: The equality flag is forced to "not equal" before each pass, so a match in a previous request cannot carry acceptance into a following mismatching request.
- R7: Done is high for exactly one cycle, and result keeps its value from that cycle until the next accepted start.
- R8: A start pulse that arrives while a request is in progress is ignored: the verdict, the latency and the single done pulse are unchanged.
- R9: If the first pass and the second pass disagree (in either direction), the verdict is 1 and alarm goes to 1. Alarm stays at 1 through later requests until reset.
- R10: While a request is in progress and done is low, result reads 1. No partly assembled acceptance value ever appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| sig_enc | input | 256 | Encoding taken from the signature; held from start to done |
| calc_enc | input | 256 | Recomputed encoding; held from start to done |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Verdict word: 1 on rejection, 0xBA11FADE0B5E55ED on acceptance |
| alarm | output | 1 | Sticky flag: the two passes disagreed |

## Verification
The bench flips every one of the 256 operand bits in turn. A comparator that reduced only part of the XOR difference would accept one of those flips.

It runs an accepted request immediately before a mismatching one. A flag that was not cleared between requests would then turn the second request into an acceptance.

It changes the operands between the two passes in both directions. A design that trusted only one pass would accept, or would leave the alarm low.

It also watches result on every busy cycle and pulses start in mid-request. A design that wrote the accumulator out early, or restarted on a busy start, would show a partial word or a shifted done.

// File: rtl/verdict_pkg.sv
// Shared sizes and verdict codes for the signature verdict comparator.
// Assumes the result width is a whole number of bytes.
package verdict_pkg;
    localparam int OPER_W = 256;
    localparam int RES_W  = 64;
    localparam int BYTE_W = 8;
    localparam logic [RES_W-1:0] ACCEPT_CODE = 64'hBA11FADE0B5E55ED;
    localparam logic [RES_W-1:0] REJECT_CODE = 64'd1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CLR1, ST_CMP1, ST_CLR2, ST_CMP2,
        ST_DECIDE, ST_BUILD, ST_WRITE, ST_DONE
    } vstate_t;
endpackage

// File: rtl/xor_zero_cmp.sv
// Equality unit: XORs two operands, reduces the difference to a zero test
// in CHUNK-wide slices, and holds the outcome in a flag register.
// Assumes W is a multiple of CHUNK. clr has priority over sample.
module xor_zero_cmp #(
    parameter int W     = 256,
    parameter int CHUNK = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         eq_flag
);
    localparam int NCH = W / CHUNK;

    logic [W-1:0]   diff;
    logic [NCH-1:0] slice_zero;
    logic           all_zero;

    // Bitwise difference of the two encodings.
    assign diff = op_a ^ op_b;

    // One zero detector per slice of the difference.
    for (genvar g = 0; g < NCH; g++) begin : g_slice
        assign slice_zero[g] = (diff[g*CHUNK +: CHUNK] == '0);
    end

    // All slices zero means the encodings are identical.
    assign all_zero = &slice_zero;

    // Flag register: forced to not-equal by clr, loaded by sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      eq_flag <= 1'b0;
        else if (clr)    eq_flag <= 1'b0;
        else if (sample) eq_flag <= all_zero;
    end

    // R6
    flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !eq_flag);
endmodule

// File: rtl/accept_builder.sv
// Acceptance-word accumulator: load seeds it with the top byte of CODE,
// each step rotates it left by one byte and ORs in the next byte.
// Assumes RES_W is a multiple of BYTE_W. last marks the final step.
module accept_builder #(
    parameter int               RES_W  = 64,
    parameter int               BYTE_W = 8,
    parameter logic [RES_W-1:0] CODE   = 64'hBA11FADE0B5E55ED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [RES_W-1:0] acc,
    output logic             last
);
    localparam int NB = RES_W / BYTE_W;
    localparam int IW = (NB > 2) ? $clog2(NB) : 1;

    logic [IW-1:0]     idx;
    logic [RES_W-1:0]  shifted;
    logic [BYTE_W-1:0] next_byte;
    logic [RES_W-1:0]  rotated;

    // Select the byte of CODE to merge at the current index.
    always_comb begin
        shifted   = CODE >> (BYTE_W * (NB - 1 - int'(idx)));
        next_byte = shifted[BYTE_W-1:0];
        rotated   = {acc[RES_W-BYTE_W-1:0], acc[RES_W-1 -: BYTE_W]};
    end

    // The step at this index merges the final byte.
    assign last = (int'(idx) == NB - 1);

    // Accumulator and byte index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (load) begin
            acc <= {{(RES_W-BYTE_W){1'b0}}, CODE[RES_W-1 -: BYTE_W]};
            idx <= IW'(1);
        end else if (step) begin
            acc <= rotated | {{(RES_W-BYTE_W){1'b0}}, next_byte};
            idx <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/verdict_ctrl.sv
// Sequencer: runs clear/compare twice, decides, drives the accumulator,
// and owns the verdict register and the sticky alarm.
// Assumes eq_flag comes from a register cleared by clr and loaded by sample.
module verdict_ctrl #(
    parameter int               RES_W       = 64,
    parameter logic [RES_W-1:0] ACCEPT_CODE = 64'hBA11FADE0B5E55ED,
    parameter logic [RES_W-1:0] REJECT_CODE = 64'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             eq_flag,
    input  logic             build_last,
    input  logic [RES_W-1:0] acc,
    output logic             clr,
    output logic             sample,
    output logic             build_load,
    output logic             build_step,
    output logic             done,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             alarm
);
    import verdict_pkg::*;

    vstate_t state;
    logic    pass1;

    // Strobes decoded from the current state.
    assign clr        = (state == ST_CLR1) || (state == ST_CLR2);
    assign sample     = (state == ST_CMP1) || (state == ST_CMP2);
    assign build_load = (state == ST_DECIDE) && pass1 && eq_flag;
    assign build_step = (state == ST_BUILD);
    assign done       = (state == ST_DONE);
    assign busy       = (state != ST_IDLE);

    // State, first-pass record, verdict register and alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pass1  <= 1'b0;
            result <= REJECT_CODE;
            alarm  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    result <= REJECT_CODE;
                    state  <= ST_CLR1;
                end
                ST_CLR1: state <= ST_CMP1;
                ST_CMP1: state <= ST_CLR2;
                ST_CLR2: begin
                    pass1 <= eq_flag;
                    state <= ST_CMP2;
                end
                ST_CMP2: state <= ST_DECIDE;
                ST_DECIDE: begin
                    if (pass1 && eq_flag) begin
                        state <= ST_BUILD;
                    end else begin
                        if (pass1 != eq_flag) alarm <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                ST_BUILD: if (build_last) state <= ST_WRITE;
                ST_WRITE: begin
                    result <= acc;
                    state  <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    reject_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (result == REJECT_CODE));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || (!busy && !start)) |=> $stable(result));
    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);
    // R4
    verdict_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == ACCEPT_CODE || result == REJECT_CODE));
    // R10
    no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> (result == REJECT_CODE));
endmodule

// File: rtl/verdict_top.sv
// Top of the fault-hardened signature verdict comparator.
// Assumes sig_enc and calc_enc are held stable from start until done.
module verdict_top #(
    parameter int                       OPER_W      = verdict_pkg::OPER_W,
    parameter int                       RES_W       = verdict_pkg::RES_W,
    parameter int                       BYTE_W      = verdict_pkg::BYTE_W,
    parameter int                       CHUNK       = 32,
    parameter logic [RES_W-1:0] ACCEPT_CODE = verdict_pkg::ACCEPT_CODE,
    parameter logic [RES_W-1:0] REJECT_CODE = verdict_pkg::REJECT_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPER_W-1:0] sig_enc,
    input  logic [OPER_W-1:0] calc_enc,
    output logic              done,
    output logic [RES_W-1:0]  result,
    output logic              alarm
);
    logic             clr, sample, eq_flag;
    logic             build_load, build_step, build_last, busy;
    logic [RES_W-1:0] acc;

    xor_zero_cmp #(.W(OPER_W), .CHUNK(CHUNK)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sample(sample),
        .op_a(sig_enc), .op_b(calc_enc), .eq_flag(eq_flag)
    );

    accept_builder #(.RES_W(RES_W), .BYTE_W(BYTE_W), .CODE(ACCEPT_CODE)) u_build (
        .clk(clk), .rst_n(rst_n), .load(build_load), .step(build_step),
        .acc(acc), .last(build_last)
    );

    verdict_ctrl #(.RES_W(RES_W), .ACCEPT_CODE(ACCEPT_CODE),
                   .REJECT_CODE(REJECT_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .eq_flag(eq_flag),
        .build_last(build_last), .acc(acc), .clr(clr), .sample(sample),
        .build_load(build_load), .build_step(build_step), .done(done),
        .busy(busy), .result(result), .alarm(alarm)
    );
endmodule

// File: tb/sim_verdict_top.sv
module sim_verdict_top;
    localparam logic [63:0] ACC = 64'hBA11FADE0B5E55ED;
    localparam logic [63:0] REJ = 64'd1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] sig_enc = '0;
    logic [255:0] calc_enc = '0;
    logic         done;
    logic [63:0]  result;
    logic         alarm;

    int  checks = 0;
    int  errors = 0;
    bit  alarm_exp = 1'b0;
    bit  finished = 1'b0;

    verdict_top u0 (.clk(clk), .rst_n(rst_n), .start(start), .sig_enc(sig_enc),
                    .calc_enc(calc_enc), .done(done), .result(result), .alarm(alarm));

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        alarm_exp = 1'b0;
    endtask

    // a/b held for pass 1; a2/b2 applied after edge 3, seen by pass 2.
    task automatic run_op(input logic [255:0] a, input logic [255:0] b,
                          input logic [255:0] a2, input logic [255:0] b2,
                          input bit busy_start, input string req);
        bit p1, p2, acc_exp, partial_ok;
        int n;
        p1 = (a == b);
        p2 = (a2 == b2);
        acc_exp = p1 && p2;
        if (p1 != p2) alarm_exp = 1'b1;
        partial_ok = 1'b1;
        @(negedge clk);
        sig_enc = a;
        calc_enc = b;
        start = 1'b1;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) start = 1'b0;
            if (n == 3) begin
                sig_enc = a2;
                calc_enc = b2;
            end
            if (busy_start && n == 4) start = 1'b1;
            if (busy_start && n == 5) start = 1'b0;
            if (n == 1) check({req, " R2 reject loaded"}, result, REJ);
            if (done) break;
            if (result !== REJ) partial_ok = 1'b0;
            if (n > 100) break;
        end
        check({req, " R10 no partial word"}, 64'(partial_ok), 64'd1);
        check({req, " R5 latency"}, 64'(n), acc_exp ? 64'd14 : 64'd6);
        check({req, acc_exp ? " R4 accept" : " R3 reject"}, result, acc_exp ? ACC : REJ);
        check({req, " R9 alarm"}, 64'(alarm), 64'(alarm_exp));
        @(negedge clk);
        check({req, " R7 done pulse"}, 64'(done), 64'd0);
        check({req, " R7 result held"}, result, acc_exp ? ACC : REJ);
        if (busy_start) begin
            repeat (3) @(negedge clk);
            check({req, " R8 no second done"}, 64'(done), 64'd0);
        end
    endtask

    initial begin
        logic [255:0] a, b;
        do_reset();
        // R1 reset state
        check("R1 result", result, REJ);
        check("R1 done", 64'(done), 64'd0);
        check("R1 alarm", 64'(alarm), 64'd0);

        // R4 identical operands, several patterns
        run_op('0, '0, '0, '0, 1'b0, "zeros");
        run_op('1, '1, '1, '1, 1'b0, "ones");
        for (int k = 0; k < 6; k++) begin
            a = rnd256();
            run_op(a, a, a, a, 1'b0, "random equal");
        end
        run_op('1, '0, '1, '0, 1'b0, "ones vs zeros");

        // R3 sweep of single-bit differences, each after an accept (R6)
        for (int i = 0; i < 256; i++) begin
            a = rnd256();
            b = a ^ (256'd1 << i);
            if (i % 16 == 0) run_op(a, a, a, a, 1'b0, "R6 prior accept");
            run_op(a, b, a, b, 1'b0, "R3 R6 bit flip");
        end

        // R8 start while busy, on both outcomes
        a = rnd256();
        run_op(a, a, a, a, 1'b1, "R8 busy accept");
        run_op(a, ~a, a, ~a, 1'b1, "R8 busy reject");

        // R9 pass disagreement, both directions; alarm stays set
        a = rnd256();
        b = a ^ 256'd1;
        run_op(a, a, a, b, 1'b0, "R9 eq then ne");
        run_op(a, b, a, a, 1'b0, "R9 ne then eq");
        run_op(a, a, a, a, 1'b0, "R9 sticky accept");

        do_reset();
        check("R1 alarm cleared", 64'(alarm), 64'd0);
        check("R1 result after reset", result, REJ);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule